// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block gathers eight interrupt request lines, picks the most urgent one that software has not masked and is not already outranked by a line being serviced, and raises a single interrupt output. When the processor acknowledges, the block answers with an eight-bit vector formed from a programmed base and the winning line number. Two of these controllers can be chained: the one programmed as master hands an acknowledge on a chained line over to a downstream controller by publishing that line number on its cascade output, and the one strapped as slave answers only when the cascade number presented to it matches its own identity.

Software talks to the block through a two-address register port. The command address (address 0) accepts the initialization opener, the status-select commands and the specific end-of-interrupt command, and reads back either the request or the in-service register. The data address (address 1) carries the three follow-up initialization words and, once initialized, reads and writes the mask. An initialization state machine steps through the states ST_RUN, ST_BASE, ST_CASC and ST_MODE. Its transitions are: any state to ST_BASE on the opener 0x11 written to the command address; ST_BASE to ST_CASC, ST_CASC to ST_MODE and ST_MODE to ST_RUN, each on a write to the data address. ST_RUN stays in ST_RUN on a data write, which loads the mask instead.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at address 1, the request register reads 0x00 at address 0, the in-service register is clear and int_out is low.
- R2: Writing 0x11 to address 0 starts initialization and clears the request and in-service registers and resets readback to the request register; the next three writes to address 1 load, in order, the vector base (its low three bits are forced to zero), the cascade word and the mode word. The mask is left unchanged.
- R3: In ST_RUN a write to address 1 loads the mask (a 1 masks the line) and a read of address 1 returns it; a masked request never raises int_out.
- R4: Writing 0x0B to address 0 makes later address-0 reads return the in-service register and 0x0A makes them return the request register; the choice persists across other writes.
- R5: Line 0 has the highest priority and line 7 the lowest; int_out is high exactly when some unmasked pending line has higher priority than every set in-service bit.
- R6: An acknowledge pulse takes the highest-priority eligible line n: one cycle later vec_valid pulses with vec_out equal to base plus n, in-service bit n is set and request bit n is cleared.
- R7: Writing 0x60 plus n to address 0 in ST_RUN clears in-service bit n only.
- R8: When bit 1 of the mode word is set (automatic end-of-interrupt), an acknowledge never sets an in-service bit.
- R9: If no line is eligible when the acknowledge arrives, the vector base plus 7 is delivered and in-service bit 7 is not set, even when line 7 is masked.
- R10: A line with its req_level bit low latches on a rising edge and stays pending until acknowledged, and a level still held after acknowledge does not re-request; a line with req_level high follows its input level.
- R11: In master role an acknowledge of a line whose cascade-word bit is set produces cas_valid with cas_out equal to that line number one cycle later, no vector, and sets that line's in-service bit.
- R12: In slave role an acknowledge is answered only when cas_sel_valid is high and cas_sel_in equals the low three bits of the cascade word; otherwise no vector appears and the request register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| req_in | input | 8 | Interrupt request lines |
| req_level | input | 8 | Per-line level-sensitive select |
| role_slave | input | 1 | 1 = slave role, 0 = master role |
| ack | input | 1 | Acknowledge pulse from the processor |
| cas_sel_in | input | 3 | Cascade line number presented to a slave |
| cas_sel_valid | input | 1 | cas_sel_in is valid |
| int_out | output | 1 | Interrupt request to the processor or master |
| vec_valid | output | 1 | vec_out is valid for one cycle |
| vec_out | output | 8 | Interrupt vector |
| cas_out | output | 3 | Cascade line number handed downstream |
| cas_valid | output | 1 | cas_out is valid for one cycle |

## Verification
The hardest situation to reach is the spurious acknowledge: the request must appear, raise int_out and then vanish before the acknowledge arrives, which only a level-mode line can do because an edge-latched request stays pending. The stimulus selects level mode on line 4, masks line 7, lets line 4 raise the interrupt, drops it so the request register empties, and only then acknowledges, expecting the line-7 vector with the in-service register still clear. The slave-role cases are reached by re-initializing the same instance with the role input flipped and driving the cascade select by hand.

// File: rtl/cic_pkg.sv
package cic_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_t;

    localparam logic [7:0] CMD_INIT    = 8'h11;
    localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
    localparam logic [4:0] CMD_SEOI_HI = 5'b01100;
    localparam int         MODE_AEOI_BIT = 1;
endpackage

// File: rtl/cic_req_reg.sv
module cic_req_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] level_sel,
    input  logic [N-1:0] ack_clr,
    input  logic         init_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    assign rise = lines & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr    <= '0;
        end else begin
            prev_q <= lines;
            if (init_clr) begin
                irr <= '0;
            end else begin
                irr <= (level_sel & lines) |
                       (~level_sel & ((irr & ~ack_clr) | rise));
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R10
        edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!init_clr && !level_sel[i] && lines[i] && !prev_q[i]) |=> irr[i]);
    end
endmodule

// File: rtl/cic_prio.sv
module cic_prio #(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   pending,
    input  logic [N-1:0]   isr,
    output logic           has_win,
    output logic [IDW-1:0] win_idx
);
    logic         any_pend;
    logic [IDW:0] isr_top;

    always_comb begin
        any_pend = 1'b0;
        win_idx  = '0;
        isr_top  = (IDW+1)'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                any_pend = 1'b1;
                win_idx  = IDW'(i);
            end
            if (isr[i]) begin
                isr_top = (IDW+1)'(i);
            end
        end
        has_win = any_pend && ({1'b0, win_idx} < isr_top);
    end
endmodule

// File: rtl/cic_port_fsm.sv
module cic_port_fsm
    import cic_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_addr,
    input  logic [7:0]     bus_wdata,
    output logic [N-1:0]   imr,
    output logic [7:0]     base,
    output logic [7:0]     cas_word,
    output logic           aeoi,
    output logic           rd_isr,
    output logic           init_clr,
    output logic           eoi_valid,
    output logic [IDW-1:0] eoi_idx
);
    init_st_t state_q, state_d;
    logic     cmd_wr, dat_wr;

    assign cmd_wr    = bus_wr && !bus_addr;
    assign dat_wr    = bus_wr && bus_addr;
    assign init_clr  = cmd_wr && (bus_wdata == CMD_INIT);
    assign eoi_valid = cmd_wr && (state_q == ST_RUN) &&
                       (bus_wdata[7:3] == CMD_SEOI_HI);
    assign eoi_idx   = bus_wdata[IDW-1:0];

    always_comb begin
        state_d = state_q;
        if (init_clr) begin
            state_d = ST_BASE;
        end else if (dat_wr) begin
            unique case (state_q)
                ST_BASE: state_d = ST_CASC;
                ST_CASC: state_d = ST_MODE;
                ST_MODE: state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr      <= '1;
            base     <= '0;
            cas_word <= '0;
            aeoi     <= 1'b0;
            rd_isr   <= 1'b0;
        end else if (init_clr) begin
            rd_isr <= 1'b0;
        end else if (cmd_wr && state_q == ST_RUN) begin
            if (bus_wdata == CMD_SEL_IRR) rd_isr <= 1'b0;
            if (bus_wdata == CMD_SEL_ISR) rd_isr <= 1'b1;
        end else if (dat_wr) begin
            unique case (state_q)
                ST_RUN:  imr      <= bus_wdata[N-1:0];
                ST_BASE: base     <= {bus_wdata[7:IDW], {IDW{1'b0}}};
                ST_CASC: cas_word <= bus_wdata;
                ST_MODE: aeoi     <= bus_wdata[MODE_AEOI_BIT];
            endcase
        end
    end

    // R2
    init_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (state_q == ST_BASE));

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && state_q == ST_RUN && !init_clr) |=> (imr == $past(bus_wdata[N-1:0])));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_addr,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic [N-1:0]   req_in,
    input  logic [N-1:0]   req_level,
    input  logic           role_slave,
    input  logic           ack,
    input  logic [IDW-1:0] cas_sel_in,
    input  logic           cas_sel_valid,
    output logic           int_out,
    output logic           vec_valid,
    output logic [7:0]     vec_out,
    output logic [IDW-1:0] cas_out,
    output logic           cas_valid
);
    logic [N-1:0]   imr, irr, isr_q, pending;
    logic [N-1:0]   win_oh, ack_clr, isr_set, isr_clr;
    logic [7:0]     base, cas_word;
    logic           aeoi, rd_isr, init_clr, eoi_valid;
    logic [IDW-1:0] eoi_idx, win_idx, vec_idx;
    logic           has_win, slave_hit, ack_fire, spur, to_cascade;

    cic_port_fsm #(.N(N), .IDW(IDW)) u_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .imr(imr), .base(base), .cas_word(cas_word),
        .aeoi(aeoi), .rd_isr(rd_isr), .init_clr(init_clr),
        .eoi_valid(eoi_valid), .eoi_idx(eoi_idx)
    );

    cic_req_reg #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(req_in), .level_sel(req_level),
        .ack_clr(ack_clr), .init_clr(init_clr), .irr(irr)
    );

    assign pending = irr & ~imr;

    cic_prio #(.N(N), .IDW(IDW)) u_prio (
        .pending(pending), .isr(isr_q), .has_win(has_win), .win_idx(win_idx)
    );

    assign int_out    = has_win;
    assign slave_hit  = cas_sel_valid && (cas_sel_in == cas_word[IDW-1:0]);
    assign ack_fire   = ack && (!role_slave || slave_hit);
    assign spur       = !has_win;
    assign to_cascade = !role_slave && !spur && cas_word[win_idx];
    assign win_oh     = {{(N-1){1'b0}}, 1'b1} << win_idx;
    assign ack_clr    = (ack_fire && !spur) ? win_oh : '0;
    assign isr_set    = (ack_fire && !spur && !aeoi) ? win_oh : '0;
    assign isr_clr    = eoi_valid ? ({{(N-1){1'b0}}, 1'b1} << eoi_idx) : '0;
    assign vec_idx    = spur ? IDW'(N - 1) : win_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q     <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
            cas_valid <= 1'b0;
            cas_out   <= '0;
        end else begin
            if (init_clr) isr_q <= '0;
            else          isr_q <= (isr_q & ~isr_clr) | isr_set;
            vec_valid <= ack_fire && !to_cascade;
            cas_valid <= ack_fire && to_cascade;
            if (ack_fire) begin
                vec_out <= base | {{(8-IDW){1'b0}}, vec_idx};
                cas_out <= win_idx;
            end
        end
    end

    assign bus_rdata = bus_addr ? 8'(imr) : (rd_isr ? 8'(isr_q) : 8'(irr));

    // R8
    aeoi_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && aeoi) |=> ((isr_q & ~$past(isr_q)) == '0));

    // R9
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && spur && !eoi_valid && !init_clr) |=>
            (vec_valid && vec_out[IDW-1:0] == IDW'(N - 1) &&
             isr_q[N-1] == $past(isr_q[N-1])));

    // R6
    one_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_q & ~$past(isr_q)));

    // R5
    int_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    // R12
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (role_slave && ack && !slave_hit) |=> (!vec_valid && !cas_valid));
endmodule

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] req_in = '0, req_level = '0;
    logic       role_slave = 1'b0, ack = 1'b0;
    logic [2:0] cas_sel_in = '0;
    logic       cas_sel_valid = 1'b0;
    logic       int_out, vec_valid, cas_valid;
    logic [7:0] vec_out;
    logic [2:0] cas_out;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    cascade_irq_ctrl i_cascade_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in),
        .req_level(req_level), .role_slave(role_slave), .ack(ack),
        .cas_sel_in(cas_sel_in), .cas_sel_valid(cas_sel_valid),
        .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
        .cas_out(cas_out), .cas_valid(cas_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected vector whenever one is produced.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6/R12 unexpected vector actual=%0h expected=none", vec_out);
            end else begin
                chk("R6 vector", vec_out, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic line(input int i, input logic v);
        @(negedge clk); req_in[i] = v;
        @(negedge clk);
    endtask

    task automatic do_ack(input bit expect_vec, input logic [7:0] v);
        if (expect_vec) exp_q.push_back(v);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic init4(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
        wr(0, 8'h11); wr(1, b); wr(1, c); wr(1, m);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1, d); chk("R1 mask", d, 8'hFF);
        rd(0, d); chk("R1 irr", d, 8'h00);
        chk("R1 int", int_out, 0);

        init4(8'h20, 8'h04, 8'h01);
        wr(1, 8'h00);
        rd(1, d); chk("R3 mask read", d, 8'h00);
        line(3, 1);
        chk("R5 int on line3", int_out, 1);
        rd(0, d); chk("R4 irr read", d, 8'h08);
        do_ack(1, 8'h23);
        rd(0, d); chk("R10 edge no rerequest", d, 8'h00);
        wr(0, 8'h0B);
        rd(0, d); chk("R6 isr set", d, 8'h08);
        wr(1, 8'h00);
        rd(0, d); chk("R4 select persists", d, 8'h08);
        line(5, 1);
        chk("R5 lower blocked by isr", int_out, 0);
        line(1, 1);
        chk("R5 higher preempts", int_out, 1);
        do_ack(1, 8'h21);
        rd(0, d); chk("R6 isr nested", d, 8'h0A);
        wr(0, 8'h61);
        rd(0, d); chk("R7 eoi line1 only", d, 8'h08);
        chk("R5 line5 still blocked", int_out, 0);
        wr(0, 8'h63);
        chk("R5 line5 after eoi", int_out, 1);
        do_ack(1, 8'h25);
        wr(0, 8'h65);
        rd(0, d); chk("R7 isr empty", d, 8'h00);
        line(1, 0); line(3, 0); line(5, 0);

        wr(1, 8'h40);
        line(6, 1);
        chk("R3 masked no int", int_out, 0);
        rd(1, d); chk("R3 mask readback", d, 8'h40);
        wr(1, 8'h00);
        @(negedge clk);
        chk("R3 unmask int", int_out, 1);
        do_ack(1, 8'h26);
        wr(0, 8'h66);
        line(6, 0);

        // spurious: level line 4 vanishes before acknowledge, line 7 masked
        wr(1, 8'h80);
        req_level[4] = 1'b1;
        line(4, 1);
        chk("R10 level int", int_out, 1);
        line(4, 0);
        wr(0, 8'h0A);
        rd(0, d); chk("R10 level follows", d, 8'h00);
        do_ack(1, 8'h27);
        wr(0, 8'h0B);
        rd(0, d); chk("R9 isr clear after spurious", d, 8'h00);
        req_level[4] = 1'b0;
        wr(1, 8'h00);

        // master cascade on line 2
        line(2, 1);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk("R11 cas_valid", cas_valid, 1);
        chk("R11 cas_out", cas_out, 2);
        rd(0, d); chk("R11 isr set", d, 8'h04);
        wr(0, 8'h62);
        line(2, 0);

        // automatic end of interrupt
        init4(8'h43, 8'h04, 8'h03);
        rd(1, d); chk("R2 mask kept", d, 8'h00);
        rd(0, d); chk("R2 readback irr", d, 8'h00);
        line(0, 1);
        do_ack(1, 8'h40);
        wr(0, 8'h0B);
        rd(0, d); chk("R8 no isr", d, 8'h00);
        line(0, 0);

        // slave role with identity 2
        role_slave = 1'b1;
        init4(8'h28, 8'h02, 8'h01);
        line(1, 1);
        cas_sel_in = 3'd3; cas_sel_valid = 1'b1;
        do_ack(0, 8'h00);
        rd(0, d); chk("R12 not selected irr kept", d, 8'h02);
        cas_sel_in = 3'd2;
        do_ack(1, 8'h29);
        rd(0, d); chk("R12 selected irr cleared", d, 8'h00);
        cas_sel_valid = 1'b0;

        repeat (3) @(negedge clk);
        chk("R6 all vectors seen", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule